// File: doc/BRIEF.md
# Endian-Aware Module Space Decoder

This block sits between a host access path and a carrier of up to four plug-in modules. Each host request names one of several local windows, an address, an access size of one byte or one halfword, and write data. The block turns it into a module slot number, a space code and a masked offset. For three of the windows it applies an optional big-endian correction. On byte accesses address bit 0 is inverted before any field is taken from the address. On halfword accesses the two data bytes are exchanged on the way in and on the way out.

The endian mode of each correctable window is one bit, kept in a small configuration window and read back at fixed byte offsets. A read of the acknowledge offsets of a module's interrupt space makes a one-cycle acknowledge strobe, but only for a request that is pending and level-sensitive. A request to an empty slot is marked as dropped, and its read data is forced to zero. Accesses of an illegal size, and accesses to unmapped window codes, raise an error pulse and are otherwise ignored. The decoded result appears one clock after the request. Read data is formed combinationally from the registered decode and the module's returned data.

Top module: `sd_space_decoder`

## Requirements
- R1: While reset is held, and after it is released, `out_valid`, `acc_err` and `ack_pulse` are low and all three endian bits are clear.
- R2: Window code 2 (module registers) gives slot = corrected address bits [9:8]. Corrected bits [7:6] select the space: value 2 gives space code 1 (ID), value 3 gives space code 2 (INT), and values 0 and 1 give space code 0 (I/O). The result is registered and shown with `out_valid` one cycle after the request.
- R3: In window 2 the offset is the corrected address masked to 7 bits (0x7F) in I/O space and to 6 bits (0x3F) in ID and INT space.
- R4: On a byte access (`req_size`=0), address bit 0 is inverted before slot, space and offset are extracted, when the window's endian bit is set. Window 1 uses endian bit 0, window 2 uses bit 1 and window 3 uses bit 2.
- R5: On a halfword access (`req_size`=1) to a window whose endian bit is set, the two bytes of the write data and of the returned read data are exchanged.
- R6: Window code 3 (16-bit memory) gives slot = corrected address bits [24:23], offset = bits [22:0] and space code 3.
- R7: Window code 4 (8-bit memory) gives slot = address bits [23:22], offset = bits [21:0] and space code 4. It never applies endian correction.
- R8: A read in window 2 to INT space at offset 0 or 2 pulses `ack_pulse` one cycle later, with `ack_slot` = slot and `ack_line` = offset/2. This happens only if `irq_status[slot*2+line]` is set, `irq_edge[slot*2+line]` is clear and the slot is present.
- R9: In windows 2, 3 and 4 a slot whose `slot_present` bit is clear sets `out_drop`. `host_rdata` is then zero and no acknowledge is made.
- R10: Window code 0 (configuration) sets endian bit i to `req_wdata[0]` on a write at byte offset 0x2B+4*i (i = 0..2). A read returns `cfg_byte` with the addressed endian bit ORed into bit 0, and `cfg_byte` unchanged at other offsets. It reports space code 6, slot 0 and offset = address bits [6:0].
- R11: Window code 1 (control) accepts only halfword accesses and reports space code 5, slot 0 and offset = address bits [7:0]. The following raise `acc_err` one cycle later with `out_valid` low: a byte access in window 1, a halfword access in window 4, and any access with window code 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 3 | Window code |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_addr | input | 25 | Byte address within the window |
| req_wdata | input | 16 | Host write data |
| slot_present | input | 4 | One bit per slot, set when a module is fitted |
| irq_status | input | 8 | Pending request per slot and line, index slot*2+line |
| irq_edge | input | 8 | Edge-sensitive flag per slot and line |
| mod_rdata | input | 16 | Read data returned by the module side |
| cfg_byte | input | 8 | Fixed configuration byte at the addressed offset |
| out_valid | output | 1 | Decoded request valid |
| out_write | output | 1 | Decoded direction |
| out_slot | output | 2 | Module slot |
| out_space | output | 3 | Space code |
| out_offset | output | 23 | Masked offset |
| out_wdata | output | 16 | Write data after lane correction |
| out_drop | output | 1 | Addressed slot is empty |
| acc_err | output | 1 | Illegal size or unmapped window |
| ack_pulse | output | 1 | Interrupt acknowledge strobe |
| ack_slot | output | 2 | Slot being acknowledged |
| ack_line | output | 1 | Request line being acknowledged |
| host_rdata | output | 16 | Read data to the host |

## Verification
A stuck or wrong endian bit shows up on the very next access to that window. It appears either as a slot, space or offset off by the flipped address bit, or as write and read data with the bytes exchanged. Because the bench sweeps every combination of the three bits, each bit is seen both set and clear. A wrong acknowledge qualification shows up as an extra or missing `ack_pulse` exactly one cycle after an INT-space read. A wrong presence decision shows up in that same cycle as non-zero read data or a missing drop flag.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int DATA_W = 16;
  localparam int NWIN_BE = 3;

  typedef enum logic [2:0] {
    W_CFG   = 3'd0,
    W_CTRL  = 3'd1,
    W_REGS  = 3'd2,
    W_MEM16 = 3'd3,
    W_MEM8  = 3'd4
  } win_e;

  typedef enum logic [2:0] {
    SP_IO    = 3'd0,
    SP_ID    = 3'd1,
    SP_INT   = 3'd2,
    SP_MEM16 = 3'd3,
    SP_MEM8  = 3'd4,
    SP_CTRL  = 3'd5,
    SP_CFG   = 3'd6
  } space_e;
endpackage

// File: rtl/sd_endian_cfg.sv
module sd_endian_cfg
  import sd_pkg::*;
#(
  parameter logic [6:0] BASE_OFF = 7'h2B,
  parameter int         STRIDE   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [6:0]         wr_addr,
  input  logic               wr_bit,
  input  logic [6:0]         rd_addr,
  output logic [NWIN_BE-1:0] be,
  output logic               rd_bit
);
  logic [NWIN_BE-1:0] be_q, be_d, rd_hit;

  for (genvar i = 0; i < NWIN_BE; i++) begin : g_bit
    localparam logic [6:0] OFF = BASE_OFF + 7'(STRIDE * i);
    always_comb begin
      be_d[i]   = be_q[i];
      if (wr_en && (wr_addr == OFF)) be_d[i] = wr_bit;
      rd_hit[i] = (rd_addr == OFF) && be_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= '0;
    else if (wr_en) be_q <= be_d;
  end

  assign be     = be_q;
  assign rd_bit = |rd_hit;
endmodule

// File: rtl/sd_lane_swap.sv
module sd_lane_swap #(
  parameter int LANES = 2
) (
  input  logic               en,
  input  logic [LANES*8-1:0] d,
  output logic [LANES*8-1:0] q
);
  logic [LANES*8-1:0] rev;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rev[i*8 +: 8] = d[(LANES-1-i)*8 +: 8];
  end
  assign q = en ? rev : d;
endmodule

// File: rtl/sd_addr_split.sv
module sd_addr_split
  import sd_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int SLOTS     = 4,
  parameter int M16_LSB   = 23,
  parameter int M8_LSB    = 22,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int OFF_W    = M16_LSB
) (
  input  logic [2:0]         win,
  input  logic               size,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NWIN_BE-1:0] be,
  input  logic [SLOTS-1:0]   slot_present,
  output logic [SLOT_W-1:0]  slot,
  output logic [2:0]         space,
  output logic [OFF_W-1:0]   offset,
  output logic               present,
  output logic               swap,
  output logic               bad
);
  logic              be_win, mod_win;
  logic [ADDR_W-1:0] eff;

  always_comb begin
    unique case (win)
      W_CTRL:  be_win = be[0];
      W_REGS:  be_win = be[1];
      W_MEM16: be_win = be[2];
      default: be_win = 1'b0;
    endcase
    eff  = addr ^ ADDR_W'(be_win & ~size);
    swap = be_win & size;
  end

  always_comb begin
    bad     = 1'b0;
    mod_win = 1'b0;
    slot    = '0;
    space   = SP_CFG;
    offset  = '0;
    unique case (win)
      W_CFG: begin
        offset = OFF_W'(addr[6:0]);
      end
      W_CTRL: begin
        bad    = ~size;
        space  = SP_CTRL;
        offset = OFF_W'(addr[7:0]);
      end
      W_REGS: begin
        mod_win = 1'b1;
        slot    = eff[8 +: SLOT_W];
        unique case (eff[7:6])
          2'd2:    begin space = SP_ID;  offset = OFF_W'(eff[5:0]); end
          2'd3:    begin space = SP_INT; offset = OFF_W'(eff[5:0]); end
          default: begin space = SP_IO;  offset = OFF_W'(eff[6:0]); end
        endcase
      end
      W_MEM16: begin
        mod_win = 1'b1;
        slot    = eff[M16_LSB +: SLOT_W];
        space   = SP_MEM16;
        offset  = eff[OFF_W-1:0];
      end
      W_MEM8: begin
        mod_win = 1'b1;
        bad     = size;
        slot    = addr[M8_LSB +: SLOT_W];
        space   = SP_MEM8;
        offset  = OFF_W'(addr[M8_LSB-1:0]);
      end
      default: bad = 1'b1;
    endcase
    present = ~mod_win | slot_present[slot];
  end
endmodule

// File: rtl/sd_space_decoder.sv
module sd_space_decoder
  import sd_pkg::*;
#(
  parameter int ADDR_W  = 25,
  parameter int SLOTS   = 4,
  parameter int M16_LSB = 23,
  parameter int M8_LSB  = 22,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int OFF_W  = M16_LSB,
  localparam int IRQ_W  = SLOTS * 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_win,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [SLOTS-1:0]  slot_present,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic [IRQ_W-1:0]  irq_edge,
  input  logic [15:0]       mod_rdata,
  input  logic [7:0]        cfg_byte,
  output logic              out_valid,
  output logic              out_write,
  output logic [SLOT_W-1:0] out_slot,
  output logic [2:0]        out_space,
  output logic [OFF_W-1:0]  out_offset,
  output logic [15:0]       out_wdata,
  output logic              out_drop,
  output logic              acc_err,
  output logic              ack_pulse,
  output logic [SLOT_W-1:0] ack_slot,
  output logic              ack_line,
  output logic [15:0]       host_rdata
);
  logic [NWIN_BE-1:0] be;
  logic               cfg_rd_bit, cfg_wr;
  logic [SLOT_W-1:0]  d_slot;
  logic [2:0]         d_space;
  logic [OFF_W-1:0]   d_offset;
  logic               d_present, d_swap, d_bad;
  logic [15:0]        d_wdata, rd_swapped;
  logic               ack_d, ack_line_d;
  logic [SLOT_W:0]    irq_idx;

  logic               r_rswap, r_cfg, r_cfgbit;

  assign cfg_wr = req_valid && req_write && (req_win == W_CFG);

  sd_endian_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_addr (req_addr[6:0]),
    .wr_bit  (req_wdata[0]),
    .rd_addr (req_addr[6:0]),
    .be      (be),
    .rd_bit  (cfg_rd_bit)
  );

  sd_addr_split #(
    .ADDR_W (ADDR_W), .SLOTS (SLOTS), .M16_LSB (M16_LSB), .M8_LSB (M8_LSB)
  ) u_split (
    .win          (req_win),
    .size         (req_size),
    .addr         (req_addr),
    .be           (be),
    .slot_present (slot_present),
    .slot         (d_slot),
    .space        (d_space),
    .offset       (d_offset),
    .present      (d_present),
    .swap         (d_swap),
    .bad          (d_bad)
  );

  sd_lane_swap u_wswap (.en (d_swap),  .d (req_wdata), .q (d_wdata));
  sd_lane_swap u_rswap (.en (r_rswap), .d (mod_rdata), .q (rd_swapped));

  // next-state for the acknowledge strobe
  always_comb begin
    ack_line_d = d_offset[1];
    irq_idx    = {d_slot, ack_line_d};
    ack_d      = req_valid && !req_write && !d_bad && d_present &&
                 (d_space == SP_INT) && (d_offset[5:0] inside {6'd0, 6'd2}) &&
                 irq_status[irq_idx] && !irq_edge[irq_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_err   <= 1'b0;
      ack_pulse <= 1'b0;
    end else begin
      out_valid <= req_valid && !d_bad;
      acc_err   <= req_valid && d_bad;
      ack_pulse <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_slot <= '0;
      ack_line <= 1'b0;
    end else if (ack_d) begin
      ack_slot <= d_slot;
      ack_line <= ack_line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write  <= 1'b0;
      out_slot   <= '0;
      out_space  <= '0;
      out_offset <= '0;
      out_wdata  <= '0;
      out_drop   <= 1'b0;
      r_rswap    <= 1'b0;
      r_cfg      <= 1'b0;
      r_cfgbit   <= 1'b0;
    end else if (req_valid) begin
      out_write  <= req_write;
      out_slot   <= d_slot;
      out_space  <= d_space;
      out_offset <= d_offset;
      out_wdata  <= d_wdata;
      out_drop   <= !d_present;
      r_rswap    <= d_swap;
      r_cfg      <= (req_win == W_CFG);
      r_cfgbit   <= cfg_rd_bit;
    end
  end

  always_comb begin
    if (r_cfg)         host_rdata = {8'h00, cfg_byte | {7'b0, r_cfgbit}};
    else if (out_drop) host_rdata = '0;
    else               host_rdata = rd_swapped;
  end

  AST_ACK_READ_INT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> (!out_write && out_space == SP_INT && out_valid)); // R8
  AST_ACK_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> !out_drop); // R9
  AST_DROP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_drop && !r_cfg) |-> (host_rdata == 16'h0000)); // R9
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (!out_valid && !ack_pulse)); // R11
  AST_MEM8_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_space == SP_MEM8) |-> (out_wdata == $past(req_wdata))); // R7
  AST_ERR_AFTER_BAD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win == W_CTRL && !req_size) |=> acc_err); // R11
endmodule

// File: tb/sd_space_decoder_tb.sv
module sd_space_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_size;
  logic [2:0]  req_win;
  logic [24:0] req_addr;
  logic [15:0] req_wdata, mod_rdata;
  logic [3:0]  slot_present;
  logic [7:0]  irq_status, irq_edge, cfg_byte;
  logic        out_valid, out_write, out_drop, acc_err, ack_pulse, ack_line;
  logic [1:0]  out_slot, ack_slot;
  logic [2:0]  out_space;
  logic [22:0] out_offset;
  logic [15:0] out_wdata, host_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int vec_id = 0;
  logic [2:0] be_m = 3'b000;

  always #10 clk = ~clk;

  sd_space_decoder u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
    .req_win (req_win), .req_size (req_size), .req_addr (req_addr),
    .req_wdata (req_wdata), .slot_present (slot_present),
    .irq_status (irq_status), .irq_edge (irq_edge), .mod_rdata (mod_rdata),
    .cfg_byte (cfg_byte), .out_valid (out_valid), .out_write (out_write),
    .out_slot (out_slot), .out_space (out_space), .out_offset (out_offset),
    .out_wdata (out_wdata), .out_drop (out_drop), .acc_err (acc_err),
    .ack_pulse (ack_pulse), .ack_slot (ack_slot), .ack_line (ack_line),
    .host_rdata (host_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s vec=%0d actual=%h expected=%h", tag, vec_id, act, exp);
    end
  endtask

  function automatic logic [15:0] bswap(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic apply(input logic [2:0] w, input logic wr, input logic sz,
                       input logic [24:0] a, input logic [15:0] wd);
    logic        bad, bew, drop, swp, ack, cbit;
    logic [24:0] ea;
    logic [1:0]  slot;
    logic [2:0]  sp;
    logic [22:0] off;
    logic [3:0]  pres;
    logic [7:0]  st, ed;
    logic [15:0] mrd;
    logic [31:0] h;
    string       tg;
    vec_id++;
    h    = 32'(vec_id);
    pres = 4'(h * 7);
    st   = 8'(h * 13);
    ed   = 8'(h * 5);
    mrd  = 16'(h * 32'h3B1) ^ 16'h5A00;
    bad  = (w > 3'd4) || (w == 3'd1 && !sz) || (w == 3'd4 && sz);
    bew  = (w == 3'd1) ? be_m[0] : (w == 3'd2) ? be_m[1] : (w == 3'd3) ? be_m[2] : 1'b0;
    ea   = (bew && !sz) ? (a ^ 25'd1) : a;
    slot = 2'd0; sp = 3'd6; off = 23'(a[6:0]); drop = 1'b0;
    case (w)
      3'd1: begin sp = 3'd5; off = 23'(a[7:0]); end
      3'd2: begin
        slot = ea[9:8];
        sp   = (ea[7:6] == 2'd2) ? 3'd1 : (ea[7:6] == 2'd3) ? 3'd2 : 3'd0;
        off  = (ea[7:6] >= 2'd2) ? 23'(ea & 25'h3F) : 23'(ea & 25'h7F);
      end
      3'd3: begin slot = 2'(ea >> 23); sp = 3'd3; off = 23'(ea & 25'h7FFFFF); end
      3'd4: begin slot = 2'(a >> 22); sp = 3'd4; off = 23'(a & 25'h3FFFFF); end
      default: ;
    endcase
    if (w >= 3'd2 && w <= 3'd4) drop = !pres[slot];
    swp  = bew && sz;
    ack  = !wr && !bad && w == 3'd2 && sp == 3'd2 && !drop && (off == 23'd0 || off == 23'd2) &&
           st[{slot, off[1]}] && !ed[{slot, off[1]}];
    cbit = (a[6:0] == 7'h2B) ? be_m[0] : (a[6:0] == 7'h2F) ? be_m[1] :
           (a[6:0] == 7'h33) ? be_m[2] : 1'b0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_win = w; req_size = sz;
    req_addr = a; req_wdata = wd; slot_present = pres;
    irq_status = st; irq_edge = ed; mod_rdata = mrd; cfg_byte = 8'(h * 3);
    @(negedge clk);
    req_valid = 1'b0;

    chk("R11 valid", 32'(out_valid), 32'(!bad));
    chk("R11 err",   32'(acc_err),   32'(bad));
    chk("R8 ack",    32'(ack_pulse), 32'(ack));
    if (ack) begin
      chk("R8 ack_slot", 32'(ack_slot), 32'(slot));
      chk("R8 ack_line", 32'(ack_line), 32'(off[1]));
    end
    if (!bad) begin
      tg = (w == 3'd2) ? "R2" : (w == 3'd3) ? "R6" : (w == 3'd4) ? "R7" :
           (w == 3'd1) ? "R11" : "R10";
      chk(tg, 32'(out_slot), 32'(slot));
      chk(tg, 32'(out_space), 32'(sp));
      tg = (bew && !sz) ? "R4" : (w == 3'd2) ? "R3" : tg;
      chk(tg, 32'(out_offset), 32'(off));
      chk(w == 3'd4 ? "R7 wdata" : "R5 wdata", 32'(out_wdata), 32'(swp ? bswap(wd) : wd));
      if (w != 3'd0) chk("R9 drop", 32'(out_drop), 32'(drop));
      if (!wr) begin
        if (w == 3'd0)   chk("R10 readback", 32'(host_rdata), 32'({8'h00, cfg_byte | {7'b0, cbit}}));
        else if (drop)   chk("R9 zero read", 32'(host_rdata), 32'h0);
        else             chk("R5 rdata", 32'(host_rdata), 32'(swp ? bswap(mrd) : mrd));
      end
      if (w == 3'd0 && wr) begin
        if (a[6:0] == 7'h2B) be_m[0] = wd[0];
        if (a[6:0] == 7'h2F) be_m[1] = wd[0];
        if (a[6:0] == 7'h33) be_m[2] = wd[0];
      end
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [6:0]  offs [6];
    logic [22:0] moff [4];
    offs = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h3E, 7'h7F};
    moff = '{23'h0, 23'h1, 23'h7FFFFE, 23'h123457};
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_win = 3'd0; req_size = 1'b0;
    req_addr = '0; req_wdata = '0; slot_present = '0; irq_status = '0; irq_edge = '0;
    mod_rdata = '0; cfg_byte = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(out_valid), 32'h0);
    chk("R1 err",   32'(acc_err),   32'h0);
    chk("R1 ack",   32'(ack_pulse), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(out_valid), 32'h0);
    // R1: endian bits read back clear after reset
    apply(3'd0, 1'b0, 1'b0, 25'h2B, 16'h0);
    apply(3'd0, 1'b0, 1'b0, 25'h2F, 16'h0);
    apply(3'd0, 1'b0, 1'b0, 25'h33, 16'h0);

    for (int b = 0; b < 8; b++) begin
      // R10: program the endian bits
      apply(3'd0, 1'b1, 1'b0, 25'h2B, 16'hFFFE | 16'(b & 1));
      apply(3'd0, 1'b1, 1'b0, 25'h2F, 16'hFFFE | 16'((b >> 1) & 1));
      apply(3'd0, 1'b1, 1'b0, 25'h33, 16'hFFFE | 16'((b >> 2) & 1));
      apply(3'd0, 1'b1, 1'b0, 25'h2C, 16'h0001);
      foreach (offs[k]) apply(3'd0, 1'b0, k[0], 25'h28 + 25'(k), 16'h0);
      apply(3'd0, 1'b0, 1'b0, 25'h2B, 16'h0);
      apply(3'd0, 1'b0, 1'b0, 25'h2F, 16'h0);
      apply(3'd0, 1'b0, 1'b1, 25'h33, 16'h0);
      // R2 R3 R4 R5 R8 R9: module register window
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          for (int j = 0; j < 6; j++)
            for (int z = 0; z < 2; z++)
              for (int r = 0; r < 2; r++)
                apply(3'd2, r[0], z[0], 25'({s[1:0], p[1:0], 6'h0}) | 25'(offs[j] & 7'h3F),
                      16'hC3A5 ^ 16'(vec_id));
      // R6 R7: memory windows
      for (int s = 0; s < 4; s++)
        for (int j = 0; j < 4; j++)
          for (int z = 0; z < 2; z++)
            for (int r = 0; r < 2; r++) begin
              apply(3'd3, r[0], z[0], {s[1:0], moff[j]}, 16'h1E2D ^ 16'(vec_id));
              apply(3'd4, r[0], z[0], {1'b1, s[1:0], moff[j][21:0]}, 16'h7788 ^ 16'(vec_id));
            end
      // R11: control window and unmapped codes
      for (int z = 0; z < 2; z++)
        for (int r = 0; r < 2; r++) begin
          apply(3'd1, r[0], z[0], 25'h00C, 16'hBEEF);
          apply(3'd1, r[0], z[0], 25'h0FF, 16'h1234);
          apply(3'd5 + 3'(r + z), r[0], z[0], 25'h3C0, 16'hAAAA);
        end
    end
    finish_run();
  end
endmodule